// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block holds the configuration registers of a multi-function peripheral. A host reaches them through two byte-wide I/O ports: an index port at offset 0 and a data port at offset 1 of a two-byte window. The block starts locked and does nothing until the host writes the key byte 0x87 to the index port twice in a row. While the block is unlocked, the host writes a register number to the index port and then reads or writes that register through the data port. Writing 0xAA to the index port locks the block again.

Register 0x07 picks a logical device. Every register at 0x30 or above belongs to the bank of the selected device, and the registers below 0x30 are shared by all devices. Each bank holds an enable bit, several 16-bit base addresses split over register pairs, an IRQ number, an IRQ type and a few option bytes. The block drives every bank's values out as flat vectors, so the functional units can take their configuration from them.

Top module: `cfg_port`

## Requirements
- R1: After reset the block is locked, all device enables are 0 and the device select (register 0x07) reads 0x00 once the block is unlocked.
- R2: While the block is locked, writes to the data port change no register and reads of either port return 0xFF.
- R3: Two index-port writes of 0x87 in a row unlock the block. After that, an index-port read returns the current register number.
- R4: An index-port write of any value other than 0x87 between the two key writes restarts the unlock sequence, and the block stays locked.
- R5: An index-port write of 0xAA while the block is unlocked locks it again and leaves the register number unchanged.
- R6: Register 0x07 selects the logical device. Registers at 0x30 and above read and write the bank of the selected device only.
- R7: Bit 0 of register 0x30 is the device enable (1 = enabled) and drives that device's bit of `dev_en`. The other bits read back as 0.
- R8: Base address k (k = 0..NUM_BASE-1) takes its high byte from register 0x60+2k and its low byte from register 0x61+2k. It appears on `dev_base` at bit offset (dev*NUM_BASE+k)*16.
- R9: Register 0x70 drives the device's IRQ number on `dev_irq` and register 0x71 drives its IRQ type on `dev_irq_type` (0x02 = active-high, edge triggered), each at bit offset dev*8.
- R10: Option register 0xF0+j (j < NUM_OPT) drives `dev_opt` at bit offset (dev*NUM_OPT+j)*8.
- R11: Global registers 0x20 to 0x2F keep the same value whatever device is selected.
- R12: When the selected device number is NUM_DEV or higher, bank writes are ignored and bank reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Write strobe for one cycle |
| io_addr | input | 1 | Port select: 0 = index, 1 = data |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data of the port selected by io_addr |
| dev_en | output | NUM_DEV | Enable bit of each device |
| dev_base | output | NUM_DEV*NUM_BASE*16 | Base addresses of each device |
| dev_irq | output | NUM_DEV*8 | IRQ number of each device |
| dev_irq_type | output | NUM_DEV*8 | IRQ type of each device |
| dev_opt | output | NUM_DEV*NUM_OPT*8 | Option bytes of each device |

## Verification
On every cycle the assertions check the lock state machine: the key pair unlocks the block, any other byte between the keys restarts the sequence, 0xAA locks it, a locked block reads 0xFF, and no exported value moves while the block is locked. They also check the state that reset leaves. Only the bench scenarios show the register map: the device select steering accesses into the right bank, the byte order of the base address pairs, the shared global registers, and the out-of-range device number that reads as zero.

// File: rtl/cfg_port.sv
module cfg_port #(
  parameter int NUM_DEV  = 9,
  parameter int NUM_BASE = 3,
  parameter int NUM_OPT  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          io_wr,
  input  logic                          io_addr,
  input  logic [7:0]                    io_wdata,
  output logic [7:0]                    io_rdata,
  output logic [NUM_DEV-1:0]            dev_en,
  output logic [NUM_DEV*NUM_BASE*16-1:0] dev_base,
  output logic [NUM_DEV*8-1:0]          dev_irq,
  output logic [NUM_DEV*8-1:0]          dev_irq_type,
  output logic [NUM_DEV*NUM_OPT*8-1:0]  dev_opt
);
  localparam logic [1:0] S_LOCK = 2'd0, S_KEY1 = 2'd1, S_OPEN = 2'd2;
  localparam logic [7:0] KEY = 8'h87, RELOCK = 8'hAA;
  localparam int NBR = 2 * NUM_BASE;
  localparam int DW  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam int BW  = (NBR > 1) ? $clog2(NBR) : 1;
  localparam int OW  = (NUM_OPT > 1) ? $clog2(NUM_OPT) : 1;
  localparam logic [8:0] BASE_LO = 9'h060, BASE_HI = 9'(9'h060 + NBR);
  localparam logic [8:0] OPT_LO  = 9'h0F0, OPT_HI  = 9'(9'h0F0 + NUM_OPT);

  logic [1:0] state;
  logic [7:0] idx_q, ldn_q;
  logic [7:0] glob_q [16];
  logic       en_q   [NUM_DEV];
  logic [7:0] base_q [NUM_DEV][NBR];
  logic [7:0] irq_q  [NUM_DEV];
  logic [7:0] typ_q  [NUM_DEV];
  logic [7:0] opt_q  [NUM_DEV][NUM_OPT];

  logic          wr_idx, wr_dat, bank_ok, in_base, in_opt;
  logic [DW-1:0] dsel;
  logic [BW-1:0] boff;
  logic [OW-1:0] ooff;
  logic [7:0]    rd_reg;

  assign wr_idx  = io_wr && !io_addr;
  assign wr_dat  = io_wr && io_addr && (state == S_OPEN);
  assign bank_ok = (idx_q >= 8'h30) && ({24'd0, ldn_q} < NUM_DEV);
  assign dsel    = ldn_q[DW-1:0];
  assign in_base = ({1'b0, idx_q} >= BASE_LO) && ({1'b0, idx_q} < BASE_HI);
  assign in_opt  = ({1'b0, idx_q} >= OPT_LO) && ({1'b0, idx_q} < OPT_HI);
  assign boff    = BW'(idx_q - 8'h60);
  assign ooff    = OW'(idx_q - 8'hF0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_LOCK;
    end else if (wr_idx) begin
      case (state)
        S_LOCK:  state <= (io_wdata == KEY) ? S_KEY1 : S_LOCK;
        S_KEY1:  state <= (io_wdata == KEY) ? S_OPEN : S_LOCK;
        default: state <= (io_wdata == RELOCK) ? S_LOCK : S_OPEN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= 8'h00;
      ldn_q <= 8'h00;
      for (int g = 0; g < 16; g++) glob_q[g] <= 8'h00;
      for (int d = 0; d < NUM_DEV; d++) begin
        en_q[d]  <= 1'b0;
        irq_q[d] <= 8'h00;
        typ_q[d] <= 8'h00;
        for (int b = 0; b < NBR; b++) base_q[d][b] <= 8'h00;
        for (int o = 0; o < NUM_OPT; o++) opt_q[d][o] <= 8'h00;
      end
    end else begin
      if (wr_idx && state == S_OPEN && io_wdata != RELOCK)
        idx_q <= io_wdata;
      if (wr_dat) begin
        if (idx_q == 8'h07)
          ldn_q <= io_wdata;
        else if (idx_q[7:4] == 4'h2)
          glob_q[idx_q[3:0]] <= io_wdata;
        else if (bank_ok) begin
          if (idx_q == 8'h30)      en_q[dsel] <= io_wdata[0];
          else if (in_base)        base_q[dsel][boff] <= io_wdata;
          else if (idx_q == 8'h70) irq_q[dsel] <= io_wdata;
          else if (idx_q == 8'h71) typ_q[dsel] <= io_wdata;
          else if (in_opt)         opt_q[dsel][ooff] <= io_wdata;
        end
      end
    end
  end

  always_comb begin
    rd_reg = 8'h00;
    if (idx_q == 8'h07)
      rd_reg = ldn_q;
    else if (idx_q[7:4] == 4'h2)
      rd_reg = glob_q[idx_q[3:0]];
    else if (bank_ok) begin
      if (idx_q == 8'h30)      rd_reg = {7'd0, en_q[dsel]};
      else if (in_base)        rd_reg = base_q[dsel][boff];
      else if (idx_q == 8'h70) rd_reg = irq_q[dsel];
      else if (idx_q == 8'h71) rd_reg = typ_q[dsel];
      else if (in_opt)         rd_reg = opt_q[dsel][ooff];
    end
  end

  assign io_rdata = (state != S_OPEN) ? 8'hFF : (io_addr ? rd_reg : idx_q);

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    assign dev_en[d]               = en_q[d];
    assign dev_irq[d*8 +: 8]       = irq_q[d];
    assign dev_irq_type[d*8 +: 8]  = typ_q[d];
    for (genvar b = 0; b < NUM_BASE; b++) begin : g_base
      assign dev_base[(d*NUM_BASE+b)*16 +: 16] = {base_q[d][2*b], base_q[d][2*b+1]};
    end
    for (genvar o = 0; o < NUM_OPT; o++) begin : g_opt
      assign dev_opt[(d*NUM_OPT+o)*8 +: 8] = opt_q[d][o];
    end
  end
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
  parameter int NUM_DEV  = 9,
  parameter int NUM_BASE = 3,
  parameter int NUM_OPT  = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           io_wr,
  input logic                           io_addr,
  input logic [7:0]                     io_wdata,
  input logic [7:0]                     io_rdata,
  input logic [NUM_DEV-1:0]             dev_en,
  input logic [NUM_DEV*NUM_BASE*16-1:0] dev_base,
  input logic [NUM_DEV*8-1:0]           dev_irq,
  input logic [NUM_DEV*8-1:0]           dev_irq_type,
  input logic [NUM_DEV*NUM_OPT*8-1:0]   dev_opt,
  input logic [1:0]                     st
);
  logic idx_wr;
  assign idx_wr = io_wr && !io_addr;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (st == 2'd0 && dev_en == '0));

  // R2
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd2) |-> io_rdata == 8'hFF);

  // R2
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd2) |=> ($stable(dev_en) && $stable(dev_base) && $stable(dev_irq)
                      && $stable(dev_irq_type) && $stable(dev_opt)));

  // R3
  unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && idx_wr && io_wdata == 8'h87) |=> st == 2'd2);

  // R4
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && idx_wr && io_wdata != 8'h87) |=> st == 2'd0);

  // R5
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && idx_wr && io_wdata == 8'hAA) |=> st == 2'd0);
endmodule

bind cfg_port cfg_port_chk #(
  .NUM_DEV(NUM_DEV), .NUM_BASE(NUM_BASE), .NUM_OPT(NUM_OPT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_en(dev_en),
  .dev_base(dev_base), .dev_irq(dev_irq), .dev_irq_type(dev_irq_type),
  .dev_opt(dev_opt), .st(state)
);

// File: tb/tb_cfg_port.sv
module tb_cfg_port;
  localparam int ND = 9, NB = 3, NO = 4;

  logic clk = 1'b0, rst_n = 1'b0, io_wr = 1'b0, io_addr = 1'b0;
  logic [7:0] io_wdata = 8'h00, io_rdata;
  logic [ND-1:0]         dev_en;
  logic [ND*NB*16-1:0]   dev_base;
  logic [ND*8-1:0]       dev_irq, dev_irq_type;
  logic [ND*NO*8-1:0]    dev_opt;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfg_port #(.NUM_DEV(ND), .NUM_BASE(NB), .NUM_OPT(NO)) dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_en(dev_en),
    .dev_base(dev_base), .dev_irq(dev_irq), .dev_irq_type(dev_irq_type),
    .dev_opt(dev_opt));

  // {read, port, data, expected, req}; read=0 is a write of data
  localparam int NV = 39;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1,1'b0,8'h00,8'hFF,4'd2},   // R2 locked index read
    {1'b1,1'b1,8'h00,8'hFF,4'd2},   // R2 locked data read
    {1'b0,1'b1,8'h55,8'h00,4'd2},   // R2 ignored write
    {1'b0,1'b0,8'h87,8'h00,4'd3},
    {1'b1,1'b0,8'h00,8'hFF,4'd3},   // R3 one key is not enough
    {1'b0,1'b0,8'h87,8'h00,4'd3},
    {1'b0,1'b0,8'h07,8'h00,4'd3},
    {1'b1,1'b0,8'h00,8'h07,4'd3},   // R3 index read back
    {1'b1,1'b1,8'h00,8'h00,4'd1},   // R1 select is 0
    {1'b0,1'b1,8'h05,8'h00,4'd6},
    {1'b1,1'b1,8'h00,8'h05,4'd6},   // R6
    {1'b0,1'b0,8'h30,8'h00,4'd7},
    {1'b0,1'b1,8'hFF,8'h00,4'd7},
    {1'b1,1'b1,8'h00,8'h01,4'd7},   // R7 only bit 0 kept
    {1'b0,1'b0,8'h60,8'h00,4'd8},
    {1'b0,1'b1,8'h00,8'h00,4'd8},
    {1'b0,1'b0,8'h61,8'h00,4'd8},
    {1'b0,1'b1,8'h60,8'h00,4'd8},
    {1'b1,1'b1,8'h00,8'h60,4'd8},   // R8
    {1'b0,1'b0,8'h70,8'h00,4'd9},
    {1'b0,1'b1,8'h01,8'h00,4'd9},
    {1'b0,1'b0,8'h71,8'h00,4'd9},
    {1'b0,1'b1,8'h02,8'h00,4'd9},
    {1'b1,1'b1,8'h00,8'h02,4'd9},   // R9
    {1'b0,1'b0,8'h22,8'h00,4'd11},
    {1'b0,1'b1,8'hFE,8'h00,4'd11},
    {1'b0,1'b0,8'h07,8'h00,4'd6},
    {1'b0,1'b1,8'h06,8'h00,4'd6},
    {1'b0,1'b0,8'h22,8'h00,4'd11},
    {1'b1,1'b1,8'h00,8'hFE,4'd11},  // R11 shared across devices
    {1'b0,1'b0,8'h30,8'h00,4'd6},
    {1'b1,1'b1,8'h00,8'h00,4'd6},   // R6 device 6 bank is separate
    {1'b0,1'b0,8'h70,8'h00,4'd6},
    {1'b1,1'b1,8'h00,8'h00,4'd6},   // R6
    {1'b0,1'b0,8'h07,8'h00,4'd6},
    {1'b0,1'b1,8'h05,8'h00,4'd6},
    {1'b0,1'b0,8'h70,8'h00,4'd6},
    {1'b1,1'b1,8'h00,8'h01,4'd6},   // R6 device 5 bank again
    {1'b1,1'b0,8'h00,8'h70,4'd3}    // R3
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic rd(logic a, logic [7:0] exp, string req);
    @(negedge clk);
    io_wr = 1'b0; io_addr = a;
    #1 chk(req, 64'(io_rdata), 64'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    #1 chk("R1 dev_en", 64'(dev_en), 64'd0);
    chk("R1 locked read", 64'(io_rdata), 64'hFF);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      if (v[21]) rd(v[20], v[11:4], $sformatf("R%0d vec%0d", v[3:0], i));
      else       wr(v[20], v[19:12]);
    end

    // state: unlocked, device 5, index 0x70
    @(negedge clk);
    chk("R7 dev_en", 64'(dev_en), 64'(9'b000100000));
    chk("R8 base0", 64'(dev_base[(5*NB+0)*16 +: 16]), 64'h0060);
    chk("R9 irq", 64'(dev_irq[5*8 +: 8]), 64'h01);
    chk("R9 type", 64'(dev_irq_type[5*8 +: 8]), 64'h02);

    wr(0, 8'h64); wr(1, 8'h12); wr(0, 8'h65); wr(1, 8'h34);
    @(negedge clk);
    chk("R8 base2", 64'(dev_base[(5*NB+2)*16 +: 16]), 64'h1234);
    chk("R8 base1 untouched", 64'(dev_base[(5*NB+1)*16 +: 16]), 64'h0000);

    wr(0, 8'hF3); wr(1, 8'hA5);
    @(negedge clk);
    chk("R10 opt3", 64'(dev_opt[(5*NO+3)*8 +: 8]), 64'hA5);
    chk("R10 opt0", 64'(dev_opt[(5*NO+0)*8 +: 8]), 64'h00);

    // R12 out-of-range device
    wr(0, 8'h07); wr(1, 8'h0C);
    wr(0, 8'h30); wr(1, 8'h01);
    rd(1, 8'h00, "R12 bank read");
    chk("R12 enables unchanged", 64'(dev_en), 64'(9'b000100000));
    wr(0, 8'h07); wr(1, 8'h05); wr(0, 8'h30);

    // R5 relock, then R2 writes ignored
    wr(0, 8'hAA);
    rd(1, 8'hFF, "R5 relocked data");
    rd(0, 8'hFF, "R5 relocked index");
    wr(1, 8'h00);
    @(negedge clk);
    chk("R2 write ignored", 64'(dev_en), 64'(9'b000100000));

    // R4 restart of the key sequence
    wr(0, 8'h87); wr(0, 8'h12); wr(0, 8'h87);
    rd(0, 8'hFF, "R4 still locked");
    wr(0, 8'h87);
    rd(0, 8'h30, "R5 index kept / R3 unlocked");
    rd(1, 8'h01, "R3 data access");

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    #1;
    chk("R1 enables cleared", 64'(dev_en), 64'd0);
    chk("R1 irq cleared", 64'(dev_irq[5*8 +: 8]), 64'd0);
    rd(0, 8'hFF, "R1 locked after reset");
    wr(0, 8'h87); wr(0, 8'h87); wr(0, 8'h07);
    rd(1, 8'h00, "R1 select cleared");

    finish_run();
  end
endmodule